// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a narrow processor bus reach a wide, indirectly addressed register space inside a core clock domain. The processor sees eight 16-bit locations, selected by a 3-bit address and framed by active-low chip-select, write and read strobes. The strobes are treated as asynchronous: each is brought into the core domain through a two-stage synchronizer, and an action is taken once, on the detected start of the strobe. Address and write data must stay stable for the whole strobe, and the strobe must last at least three core clocks.

To write a 32-bit internal register, software first loads the two 16-bit halves into locations 0 and 1. It then writes the target internal address to location 2. This launches a fixed four-cycle sequence that ends in a single core-domain write pulse. To read a register, software writes the internal address to location 3. After the same four-cycle sequence, the result can be read from locations 0 and 1.

The internal address space has three regions: global, I/O section and channel. The I/O section and channel regions are addressed through one-hot select bits, so a single write can reach several sections or several channels at once. A read must name exactly one section or channel. A read that names more than one returns zero and sets a sticky error flag in the status word. A small register file stands in for the internal registers, so the whole path can be exercised.

Top module: `ind_reg_bridge`

## Requirements
- R1: A write to location 0 loads bits 15:0 of the pending write word, and a write to location 1 loads bits 31:16. The word issued by an internal write is the value of both halves at the moment that write was launched. Rewriting location 0 or 1 while a write is in flight does not change `core_wdata`.
- R2: Writing an address to location 2 launches an internal write. The start of the strobe is taken 3 clocks after the strobe asserts. `core_we` is then high for exactly one cycle, 6 rising edges after strobe assertion, with `core_addr` equal to the written address. `core_we` falls together with `busy`.
- R3: `busy` rises when a location-2 or location-3 access is taken and stays high for exactly 4 cycles. `core_we` is high only while `busy` is high.
- R4: Writing an address to location 3 never produces `core_we`. It launches a read, and after the read completes, location 0 returns bits 15:0 and location 1 returns bits 31:16 of the addressed register.
- R5: Reading location 3 returns the shared internal address register. Reading location 2 returns status: bit 15 is busy, bit 14 is the read error, and all other bits are zero.
- R6: Addresses 0000h-00FFh select the global registers. Addresses 0100h-0FFFh select I/O sections, with bits 8, 9, 10 and 11 selecting sections 0, 1, 2 and 3. Addresses 1000h-FFFFh select channels, with bits 12, 13, 14 and 15 selecting channels 0 to 3. Address bits 1:0 pick one of 4 registers in the selected target, and other targets are unaffected.
- R7: A write whose address sets several section or channel select bits writes the same word into every selected target.
- R8: A read whose address sets more than one section or channel select bit returns zero data and sets status bit 14.
- R9: The error bit stays set until the start of a status read (location 2) is taken, which clears it. If the clear and a new error fall in the same cycle, the bit stays set.
- R10: A location-2 or location-3 write taken while `busy` is high is ignored. It changes neither the address register nor the in-flight access, and it produces no extra `core_we`.
- R11: After reset, `busy`, `core_we`, the error bit, the read result, the address register and all test registers are zero.
- R12: `cpu_dout_en` is high exactly while chip-select and read are both asserted, and `cpu_dout` is zero otherwise. Locations 4-7 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_cs_n | input | 1 | Processor chip select, active low |
| cpu_wr_n | input | 1 | Processor write strobe, active low |
| cpu_rd_n | input | 1 | Processor read strobe, active low |
| cpu_addr | input | 3 | Direct location select |
| cpu_din | input | 16 | Processor write data |
| cpu_dout | output | 16 | Processor read data |
| cpu_dout_en | output | 1 | Read data drive enable |
| core_we | output | 1 | One-cycle internal write pulse |
| core_addr | output | 16 | Internal address register |
| core_wdata | output | 32 | Internal write word |
| busy | output | 1 | Internal access in progress |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is the completion of a read with a bad address, which sets the error, and the start of a status read, which clears it. The second pair is the last cycle of an access and a new location-2 or location-3 launch. The bench provokes both by issuing the second strobe exactly one clock after the first is released, so that both detected starts arrive on the completion edge. It then checks the status word on later reads and counts `core_we` pulses. A behavioural model that is updated on every clock predicts `busy`, `core_we`, the internal address and data, and the read bus, and the bench compares all of them every cycle.

// File: rtl/irb_pkg.sv
// Package: shared types and constants for the indirect register bridge.
// Assumes a 16-bit internal address, whose upper byte carries one-hot selects.
package irb_pkg;

    typedef enum logic [1:0] {
        RGN_GLB = 2'd0,
        RGN_IO  = 2'd1,
        RGN_CH  = 2'd2
    } region_e;

    localparam int unsigned IADDR_W = 16;
    localparam int unsigned SECT_N  = 4;

    localparam logic [2:0] LOC_DLO   = 3'd0;
    localparam logic [2:0] LOC_DHI   = 3'd1;
    localparam logic [2:0] LOC_WADDR = 3'd2;
    localparam logic [2:0] LOC_RADDR = 3'd3;

    // Number of set bits in a select nibble.
    function automatic logic [2:0] sel_count(input logic [SECT_N-1:0] v);
        logic [2:0] n;
        n = '0;
        for (int i = 0; i < SECT_N; i++) n = n + {2'b00, v[i]};
        return n;
    endfunction

endpackage

// File: rtl/irb_strobe_sync.sv
// Module: brings one asynchronous active-high strobe level into the core
// domain and flags its start for one cycle.
// Assumes the strobe stays high for more than STAGES+1 core clocks.
module irb_strobe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_async,
    output logic start
);

    logic [STAGES-1:0] pipe_q;
    logic              prev_q;

    // Purpose: synchronizer chain plus one delay stage for the edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
            prev_q <= 1'b0;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], act_async};
            prev_q <= pipe_q[STAGES-1];
        end
    end

    assign start = pipe_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/irb_region_decode.sv
// Module: splits an internal address into region, one-hot target select and
// register index, and reports whether the address names a single target.
// Assumes IDX_W <= 8, so the index lies below the select bits.
module irb_region_decode
    import irb_pkg::*;
#(
    parameter int unsigned IDX_W = 2
) (
    input  logic [IADDR_W-1:0] addr,
    output region_e            region,
    output logic [SECT_N-1:0]  sel,
    output logic [IDX_W-1:0]   idx,
    output logic               single
);

    logic [SECT_N-1:0] ch_bits;
    logic [SECT_N-1:0] io_bits;

    assign ch_bits = addr[15:12];
    assign io_bits = addr[11:8];
    assign idx     = addr[IDX_W-1:0];

    // Purpose: region priority is channel, then I/O section, then global.
    always_comb begin
        region = RGN_GLB;
        sel    = '0;
        single = 1'b1;
        if (ch_bits != '0) begin
            region = RGN_CH;
            sel    = ch_bits;
            single = (sel_count(ch_bits) == 3'd1);
        end else if (io_bits != '0) begin
            region = RGN_IO;
            sel    = io_bits;
            single = (sel_count(io_bits) == 3'd1);
        end
    end

endmodule

// File: rtl/irb_seq.sv
// Module: access sequencer. Holds the shared internal address, snapshots the
// write word at launch, runs the fixed SEQ_LEN-cycle access window, issues the
// write pulse or captures read data, and keeps the sticky read-error flag.
// Assumes SEQ_LEN >= 2; launches that arrive while busy are dropped.
module irb_seq
    import irb_pkg::*;
#(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned SEQ_LEN = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch_wr,
    input  logic               launch_rd,
    input  logic [IADDR_W-1:0] addr_in,
    input  logic [WORD_W-1:0]  wdata_in,
    input  logic               rd_ok,
    input  logic [WORD_W-1:0]  rf_rdata,
    input  logic               err_clr,
    output logic               busy,
    output logic               core_we,
    output logic [IADDR_W-1:0] core_addr,
    output logic [WORD_W-1:0]  core_wdata,
    output logic [WORD_W-1:0]  rdata,
    output logic               err
);

    localparam int unsigned CNT_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SEQ_LEN - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic             is_rd_q;
    logic             accept;
    logic             last;

    assign accept = (launch_wr | launch_rd) & ~busy_q;
    assign last   = busy_q & (cnt_q == CNT_LAST);

    // Purpose: access window state: busy flag, cycle count and access kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            is_rd_q <= 1'b0;
        end else if (accept) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            is_rd_q <= launch_rd;
        end else if (last) begin
            busy_q  <= 1'b0;
        end else if (busy_q) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Purpose: latch the shared address and the write word when a launch is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_addr  <= '0;
            core_wdata <= '0;
        end else if (accept) begin
            core_addr  <= addr_in;
            core_wdata <= wdata_in;
        end
    end

    // Purpose: capture the read result, or zero for an ambiguous target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (last && is_rd_q) begin
            rdata <= rd_ok ? rf_rdata : '0;
        end
    end

    // Purpose: sticky error flag; a new error wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (last && is_rd_q && !rd_ok) begin
            err <= 1'b1;
        end else if (err_clr) begin
            err <= 1'b0;
        end
    end

    assign busy    = busy_q;
    assign core_we = last & ~is_rd_q;

endmodule

// File: rtl/irb_regfile.sv
// Module: test register file standing in for the internal registers: one
// global bank plus SECT_N I/O-section banks and SECT_N channel banks of
// 2**IDX_W words each. A write reaches every bank whose select bit is set.
// Assumes the read side is used only when a single target is selected.
module irb_regfile
    import irb_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  region_e           region,
    input  logic [SECT_N-1:0] sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0]             glb_q [DEPTH];
    logic [SECT_N-1:0][WORD_W-1:0] io_pick;
    logic [SECT_N-1:0][WORD_W-1:0] ch_pick;

    // Purpose: global bank write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) glb_q[i] <= '0;
        end else if (we && region == RGN_GLB) begin
            glb_q[idx] <= wdata;
        end
    end

    for (genvar s = 0; s < SECT_N; s++) begin : g_bank
        logic [WORD_W-1:0] io_q [DEPTH];
        logic [WORD_W-1:0] ch_q [DEPTH];

        // Purpose: I/O-section bank s write, taken when its select bit is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) io_q[i] <= '0;
            end else if (we && region == RGN_IO && sel[s]) begin
                io_q[idx] <= wdata;
            end
        end

        // Purpose: channel bank s write, taken when its select bit is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) ch_q[i] <= '0;
            end else if (we && region == RGN_CH && sel[s]) begin
                ch_q[idx] <= wdata;
            end
        end

        assign io_pick[s] = sel[s] ? io_q[idx] : '0;
        assign ch_pick[s] = sel[s] ? ch_q[idx] : '0;
    end

    // Purpose: read mux over the region and the selected bank.
    always_comb begin
        rdata = '0;
        case (region)
            RGN_GLB: rdata = glb_q[idx];
            RGN_IO:  for (int s = 0; s < SECT_N; s++) rdata = rdata | io_pick[s];
            RGN_CH:  for (int s = 0; s < SECT_N; s++) rdata = rdata | ch_pick[s];
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/ind_reg_bridge.sv
// Module: top of the indirect register bridge. Synchronizes the processor
// strobes, holds the split write word, routes direct locations, and connects
// the sequencer, the region decoder and the test register file.
// Assumes cpu_addr and cpu_din are stable for the whole strobe and that each
// strobe lasts at least SYNC_STAGES+1 core clocks.
module ind_reg_bridge
    import irb_pkg::*;
#(
    parameter int unsigned BUS_W       = 16,
    parameter int unsigned IDX_W       = 2,
    parameter int unsigned SEQ_LEN     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_cs_n,
    input  logic                 cpu_wr_n,
    input  logic                 cpu_rd_n,
    input  logic [2:0]           cpu_addr,
    input  logic [BUS_W-1:0]     cpu_din,
    output logic [BUS_W-1:0]     cpu_dout,
    output logic                 cpu_dout_en,
    output logic                 core_we,
    output logic [IADDR_W-1:0]   core_addr,
    output logic [2*BUS_W-1:0]   core_wdata,
    output logic                 busy
);

    localparam int unsigned WORD_W = 2 * BUS_W;

    logic              wr_start;
    logic              rd_start;
    logic [BUS_W-1:0]  hold_lo_q;
    logic [BUS_W-1:0]  hold_hi_q;
    logic [WORD_W-1:0] rdata;
    logic [WORD_W-1:0] rf_rdata;
    logic              err;
    region_e           region;
    logic [SECT_N-1:0] sel;
    logic [IDX_W-1:0]  idx;
    logic              single;
    logic [BUS_W-1:0]  status;

    irb_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_async (~cpu_cs_n & ~cpu_wr_n),
        .start     (wr_start)
    );

    irb_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_async (~cpu_cs_n & ~cpu_rd_n),
        .start     (rd_start)
    );

    // Purpose: split holding registers for the pending write word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_lo_q <= '0;
            hold_hi_q <= '0;
        end else if (wr_start) begin
            if (cpu_addr == LOC_DLO) hold_lo_q <= cpu_din;
            if (cpu_addr == LOC_DHI) hold_hi_q <= cpu_din;
        end
    end

    irb_seq #(.WORD_W(WORD_W), .SEQ_LEN(SEQ_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_wr  (wr_start && cpu_addr == LOC_WADDR),
        .launch_rd  (wr_start && cpu_addr == LOC_RADDR),
        .addr_in    (IADDR_W'(cpu_din)),
        .wdata_in   ({hold_hi_q, hold_lo_q}),
        .rd_ok      (single),
        .rf_rdata   (rf_rdata),
        .err_clr    (rd_start && cpu_addr == LOC_WADDR),
        .busy       (busy),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .rdata      (rdata),
        .err        (err)
    );

    irb_region_decode #(.IDX_W(IDX_W)) u_dec (
        .addr   (core_addr),
        .region (region),
        .sel    (sel),
        .idx    (idx),
        .single (single)
    );

    irb_regfile #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (core_we),
        .region (region),
        .sel    (sel),
        .idx    (idx),
        .wdata  (core_wdata),
        .rdata  (rf_rdata)
    );

    assign status      = {busy, err, {(BUS_W-2){1'b0}}};
    assign cpu_dout_en = ~cpu_cs_n & ~cpu_rd_n;

    // Purpose: direct-location read mux, driven only while a read is active.
    always_comb begin
        cpu_dout = '0;
        if (cpu_dout_en) begin
            case (cpu_addr)
                LOC_DLO:   cpu_dout = rdata[BUS_W-1:0];
                LOC_DHI:   cpu_dout = rdata[WORD_W-1:BUS_W];
                LOC_WADDR: cpu_dout = status;
                LOC_RADDR: cpu_dout = BUS_W'(core_addr);
                default:   cpu_dout = '0;
            endcase
        end
    end

endmodule

// File: rtl/ind_reg_bridge_chk.sv
// Module: property checker bound to the bridge top; observes ports only.
// Assumes SEQ_LEN is small enough for an 8-bit window counter.
module ind_reg_bridge_chk #(
    parameter int unsigned SEQ_LEN = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        core_we,
    input logic [15:0] core_addr,
    input logic [31:0] core_wdata
);

    logic [7:0] busy_len_q;

    // Purpose: count the cycles of the current busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_len_q <= '0;
        else if (!busy) busy_len_q <= '0;
        else if (busy_len_q != 8'hFF) busy_len_q <= busy_len_q + 8'd1;
    end

    p_we_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_we |=> !core_we);

    p_we_ends_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_we |=> !busy);

    p_we_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_we |-> busy);

    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len_q == 8'(SEQ_LEN)));

    p_wdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(core_wdata));

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(core_addr));

endmodule

bind ind_reg_bridge ind_reg_bridge_chk #(.SEQ_LEN(SEQ_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .core_we    (core_we),
    .core_addr  (core_addr),
    .core_wdata (core_wdata)
);

// File: tb/ind_reg_bridge_bench.sv
module ind_reg_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_cs_n = 1'b1;
    logic        cpu_wr_n = 1'b1;
    logic        cpu_rd_n = 1'b1;
    logic [2:0]  cpu_addr = '0;
    logic [15:0] cpu_din = '0;
    logic [15:0] cpu_dout;
    logic        cpu_dout_en;
    logic        core_we;
    logic [15:0] core_addr;
    logic [31:0] core_wdata;
    logic        busy;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int wr_t0 = 0;
    int we_delay = 0;
    int we_count = 0;

    always #4 clk = ~clk;

    ind_reg_bridge u_ind_reg_bridge (
        .clk(clk), .rst_n(rst_n), .cpu_cs_n(cpu_cs_n), .cpu_wr_n(cpu_wr_n),
        .cpu_rd_n(cpu_rd_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
        .cpu_dout(cpu_dout), .cpu_dout_en(cpu_dout_en), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata), .busy(busy)
    );

    // ---------------- behavioural reference model ----------------
    bit          w1, w2, w3, r1, r2, r3;
    bit          m_busy, m_isrd, m_err;
    int          m_cnt;
    logic [15:0] m_addr, m_lo, m_hi;
    logic [31:0] m_wdata, m_rdata;
    logic [31:0] rf_g [4];
    logic [31:0] rf_io [4][4];
    logic [31:0] rf_c [4][4];

    function automatic int kind_of(input logic [15:0] a);
        if (a < 16'h0100) return 0;
        if (a < 16'h1000) return 1;
        return 2;
    endfunction

    function automatic logic [3:0] picks(input logic [15:0] a);
        if (kind_of(a) == 1) return a[11:8];
        if (kind_of(a) == 2) return a[15:12];
        return 4'b0000;
    endfunction

    function automatic bit read_ok(input logic [15:0] a);
        int n = 0;
        for (int i = 0; i < 4; i++) if (picks(a)[i]) n++;
        return (kind_of(a) == 0) || (n == 1);
    endfunction

    task automatic mdl_write(input logic [15:0] a, input logic [31:0] d);
        if (kind_of(a) == 0) rf_g[a[1:0]] = d;
        for (int s = 0; s < 4; s++) begin
            if (picks(a)[s] && kind_of(a) == 1) rf_io[s][a[1:0]] = d;
            if (picks(a)[s] && kind_of(a) == 2) rf_c[s][a[1:0]] = d;
        end
    endtask

    function automatic logic [31:0] mdl_read(input logic [15:0] a);
        if (kind_of(a) == 0) return rf_g[a[1:0]];
        for (int s = 0; s < 4; s++) begin
            if (picks(a)[s] && kind_of(a) == 1) return rf_io[s][a[1:0]];
            if (picks(a)[s] && kind_of(a) == 2) return rf_c[s][a[1:0]];
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            {w1, w2, w3, r1, r2, r3} = '0;
            m_busy = 0; m_isrd = 0; m_err = 0; m_cnt = 0;
            m_addr = '0; m_lo = '0; m_hi = '0; m_wdata = '0; m_rdata = '0;
            for (int i = 0; i < 4; i++) begin
                rf_g[i] = '0;
                for (int j = 0; j < 4; j++) begin rf_io[i][j] = '0; rf_c[i][j] = '0; end
            end
        end else begin
            bit wrise, rrise, set_err, was_busy;
            logic [31:0] snap;
            wrise = w2 && !w3;
            rrise = r2 && !r3;
            w3 = w2; w2 = w1; w1 = !cpu_cs_n && !cpu_wr_n;
            r3 = r2; r2 = r1; r1 = !cpu_cs_n && !cpu_rd_n;
            set_err = 0;
            was_busy = m_busy;
            snap = {m_hi, m_lo};
            if (m_busy) begin
                if (m_cnt == 3) begin
                    if (!m_isrd) mdl_write(m_addr, m_wdata);
                    else if (read_ok(m_addr)) m_rdata = mdl_read(m_addr);
                    else begin m_rdata = '0; set_err = 1; end
                    m_busy = 0;
                end else m_cnt++;
            end
            if (set_err) m_err = 1;
            else if (rrise && cpu_addr == 3'd2) m_err = 0;
            if (wrise) begin
                case (cpu_addr)
                    3'd0: m_lo = cpu_din;
                    3'd1: m_hi = cpu_din;
                    3'd2, 3'd3: if (!was_busy) begin
                        m_addr = cpu_din; m_busy = 1; m_cnt = 0;
                        m_isrd = (cpu_addr == 3'd3); m_wdata = snap;
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [15:0] exp_dout();
        if (cpu_cs_n || cpu_rd_n) return 16'h0;
        case (cpu_addr)
            3'd0: return m_rdata[15:0];
            3'd1: return m_rdata[31:16];
            3'd2: return {m_busy, m_err, 14'h0};
            3'd3: return m_addr;
            default: return 16'h0;
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s at cycle %0d: got %h expected %h", tag, cyc, got, exp);
        end
    endtask

    // Per-clock comparison against the model, after both have settled.
    always @(posedge clk) begin
        #2;
        if (core_we) begin
            we_delay = cyc - wr_t0;
            we_count++;
        end
        if (rst_n) begin
            cmp("R3 busy", {31'b0, busy}, {31'b0, m_busy});
            cmp("R2 core_we", {31'b0, core_we}, {31'b0, (m_busy && m_cnt == 3 && !m_isrd)});
            if (core_we) begin
                cmp("R2 core_addr", {16'b0, core_addr}, {16'b0, m_addr});
                cmp("R1 core_wdata", core_wdata, m_wdata);
            end
            cmp("R12 dout_en", {31'b0, cpu_dout_en}, {31'b0, (!cpu_cs_n && !cpu_rd_n)});
            cmp("R5 cpu_dout", {16'b0, cpu_dout}, {16'b0, exp_dout()});
        end
    end

    // ---------------- processor bus tasks ----------------
    task automatic cpu_write(input logic [2:0] loc, input logic [15:0] d);
        @(negedge clk);
        cpu_cs_n = 0; cpu_wr_n = 0; cpu_addr = loc; cpu_din = d;
        wr_t0 = cyc;
        repeat (3) @(negedge clk);
        cpu_cs_n = 1; cpu_wr_n = 1;
    endtask

    task automatic cpu_read(input logic [2:0] loc, output logic [15:0] d);
        @(negedge clk);
        cpu_cs_n = 0; cpu_rd_n = 0; cpu_addr = loc;
        #1 d = cpu_dout;
        repeat (3) @(negedge clk);
        cpu_cs_n = 1; cpu_rd_n = 1;
    endtask

    task automatic wait_idle();
        repeat (6) @(negedge clk);
    endtask

    task automatic ind_write(input logic [15:0] a, input logic [31:0] d);
        cpu_write(3'd0, d[15:0]);
        cpu_write(3'd1, d[31:16]);
        cpu_write(3'd2, a);
        wait_idle();
    endtask

    task automatic ind_read(input logic [15:0] a, output logic [31:0] d);
        logic [15:0] lo, hi;
        cpu_write(3'd3, a);
        wait_idle();
        cpu_read(3'd0, lo);
        cpu_read(3'd1, hi);
        d = {hi, lo};
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] st;
        logic [31:0] rd;
        int n0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11: reset state
        cmp("R11 busy after reset", {31'b0, busy}, 32'h0);
        cmp("R11 core_we after reset", {31'b0, core_we}, 32'h0);
        cmp("R11 dout_en idle", {31'b0, cpu_dout_en}, 32'h0);
        cpu_read(3'd2, st);
        cmp("R11 status after reset", {16'b0, st}, 32'h0);
        ind_read(16'h1002, rd);
        cmp("R11 channel register after reset", rd, 32'h0);

        // R1 R2: global write and its timing
        n0 = we_count;
        ind_write(16'h0002, 32'hABCD_1234);
        cmp("R2 write pulse delay", we_delay, 6);
        cmp("R2 one pulse per write", we_count - n0, 1);
        cpu_read(3'd3, st);
        cmp("R5 address readback", {16'b0, st}, 32'h0002);
        n0 = we_count;
        ind_read(16'h0002, rd);
        cmp("R4 readback of written word", rd, 32'hABCD_1234);
        cmp("R4 read issues no write pulse", we_count - n0, 0);

        // R3 R5: status busy bit during an access
        cpu_write(3'd3, 16'h0002);
        cpu_read(3'd2, st);
        cmp("R5 status shows busy", {16'b0, st}, 32'h8000);
        wait_idle();

        // R6 R7: I/O broadcast to sections 0 and 1
        ind_write(16'h0301, 32'h5555_AAAA);
        ind_read(16'h0101, rd);
        cmp("R7 section 0 got broadcast", rd, 32'h5555_AAAA);
        ind_read(16'h0201, rd);
        cmp("R7 section 1 got broadcast", rd, 32'h5555_AAAA);
        ind_read(16'h0401, rd);
        cmp("R6 section 2 untouched", rd, 32'h0);
        ind_read(16'h0301 & 16'h01FF | 16'h0100, rd);
        cmp("R6 I/O index 1 readback", rd, 32'h5555_AAAA);

        // R6 R7: channels
        ind_write(16'h1003, 32'h0BAD_F00D);
        ind_read(16'h2003, rd);
        cmp("R6 channel 1 untouched", rd, 32'h0);
        ind_read(16'h1003, rd);
        cmp("R6 channel 0 index 3", rd, 32'h0BAD_F00D);
        ind_write(16'hF000, 32'h1357_9BDF);
        ind_read(16'h8000, rd);
        cmp("R7 channel 3 got broadcast", rd, 32'h1357_9BDF);
        ind_read(16'h4000, rd);
        cmp("R7 channel 2 got broadcast", rd, 32'h1357_9BDF);

        // R8 R9: ambiguous read and clear on status read
        ind_read(16'h0C01, rd);
        cmp("R8 ambiguous read returns zero", rd, 32'h0);
        cpu_read(3'd2, st);
        cmp("R8 error bit set", {16'b0, st}, 32'h4000);
        cpu_read(3'd2, st);
        cmp("R9 error cleared by status read", {16'b0, st}, 32'h0);

        // R9: clear and set on the same edge; set wins
        cpu_write(3'd3, 16'h3000);
        cpu_read(3'd2, st);
        cmp("R9 status during bad read", {16'b0, st}, 32'h8000);
        wait_idle();
        cpu_read(3'd2, st);
        cmp("R9 set wins over same-cycle clear", {16'b0, st}, 32'h4000);
        cpu_read(3'd2, st);
        cmp("R9 later clear", {16'b0, st}, 32'h0);

        // R10 R1: launch on the completion edge is dropped; holds rewritten in flight
        cpu_write(3'd0, 16'h1111);
        cpu_write(3'd1, 16'h2222);
        n0 = we_count;
        cpu_write(3'd2, 16'h0001);
        cpu_write(3'd2, 16'h0003);
        wait_idle();
        cmp("R10 second launch gives no pulse", we_count - n0, 1);
        cpu_read(3'd3, st);
        cmp("R10 address kept", {16'b0, st}, 32'h0001);
        cpu_write(3'd2, 16'h0000);
        cpu_write(3'd0, 16'h9999);
        wait_idle();
        ind_read(16'h0000, rd);
        cmp("R1 in-flight word uses launch snapshot", rd, 32'h2222_1111);
        cpu_write(3'd3, 16'h0001);
        cpu_write(3'd3, 16'h0003);
        wait_idle();
        cpu_read(3'd3, st);
        cmp("R10 read launch while busy dropped", {16'b0, st}, 32'h0001);

        // R12: locations 4-7
        cpu_read(3'd5, st);
        cmp("R12 location 5 reads zero", {16'b0, st}, 32'h0);
        cpu_write(3'd6, 16'hFFFF);
        cpu_write(3'd4, 16'hFFFF);
        wait_idle();
        cpu_read(3'd2, st);
        cmp("R12 writes to 4-7 leave status", {16'b0, st}, 32'h0);
        cpu_read(3'd3, st);
        cmp("R12 writes to 4-7 leave address", {16'b0, st}, 32'h0001);

        // R6: mixed single-target traffic
        for (int i = 0; i < 16; i++) begin
            logic [15:0] a;
            logic [31:0] d;
            int k;
            k = $urandom % 3;
            a = {14'h0, 2'($urandom % 4)};
            if (k == 1) a = a | (16'h0100 << ($urandom % 4));
            if (k == 2) a = a | (16'h1000 << ($urandom % 4));
            d = $urandom;
            ind_write(a, d);
            ind_read(a, rd);
            cmp("R6 single-target readback", rd, d);
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule